// File: doc/BRIEF.md
# Cascaded Converter Result Collector

This block sits on the host side of a string of serial-output converters that share one serial clock, one select line and one sync line. Each converter feeds its serial output into the serial input of its neighbour, and the far end's input is grounded. Only the converter closest to the host drives the host. When that converter signals that data is ready by pulling its active-low ready line down, the collector runs one serial burst that is long enough to carry every converter's 24-bit result. It then cuts the single bit stream into one word per converter.

Words are delivered one at a time with a one-cycle strobe and a channel index. Index 0 is the converter wired to the host and index NUM_DEV-1 is the grounded far end. The serial clock rate comes from a divider parameter. A configuration input selects whether the select line is driven low only during a burst or held low all the time. If the ready line returns high before the burst completes, the collector raises an error pulse and abandons the frame.

Top module: `chain_collector`

## Requirements
- R1: While reset is applied and in the first cycle after it, sclk_o is 1, cs_n_o is 1, word_valid_o is 0 and err_o is 0.
- R2: A burst starts only on a low level of drdy_n_i that follows a high level seen since reset or since the previous completed burst. Holding drdy_n_i low after a burst, or from reset onward, starts no further burst.
- R3: A completed burst produces exactly 24*NUM_DEV falling edges of sclk_o. Each low and each high phase lasts SCLK_DIV clock cycles, so the first fall and the last rise are (48*NUM_DEV-1)*SCLK_DIV cycles apart.
- R4: sdo_i is sampled at each rising edge of sclk_o. Each 24-bit word is assembled MSB first, and word_o carries the two's-complement result unchanged.
- R5: The first 24 bits of a burst are reported with chan_o = 0, the next 24 bits with chan_o = 1, and so on up to chan_o = NUM_DEV-1, so that words appear in chain order starting from the converter nearest the host.
- R6: word_valid_o is high for exactly one cycle per word and never in two consecutive cycles. Each strobe carries chan_o < NUM_DEV.
- R7: With cs_en_i = 1, cs_n_o goes low when a burst begins and returns high when it ends, and sclk_o is 1 whenever cs_n_o is 1. With cs_en_i = 0, cs_n_o stays 0.
- R8: If drdy_n_i goes high before all 24*NUM_DEV bits are captured, err_o pulses for one cycle, sclk_o returns high, no further word of that frame is reported, and the next burst starts again at chan_o = 0. err_o and word_valid_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_en_i | input | 1 | 1: drive select low only during a burst; 0: hold select low |
| drdy_n_i | input | 1 | Active-low data-ready from the converter nearest the host |
| sdo_i | input | 1 | Serial data from the converter nearest the host |
| sclk_o | output | 1 | Serial clock to all converters, idle high |
| cs_n_o | output | 1 | Active-low select to all converters |
| word_o | output | 24 | Captured two's-complement result |
| chan_o | output | CHAN_W | Chain position of word_o, 0 = nearest the host |
| word_valid_o | output | 1 | One-cycle strobe marking word_o and chan_o |
| err_o | output | 1 | One-cycle pulse when ready is withdrawn mid-burst |

## Verification
The bench builds the collector with NUM_DEV = 3 and SCLK_DIV = 2. These values keep a full burst down to 72 bits and under 300 cycles, so many frames fit in one run. The bench sweeps word patterns that include the most negative and most positive codes, all zeros, all ones, walking bits and computed mixtures on every chain position. It uses both select modes. It also places the ready line low across reset, holds it low long after a burst, and withdraws it partway through a burst so that the arming, edge-count and abort paths are all exercised.

// File: rtl/chain_collector_pkg.sv
package chain_collector_pkg;

    localparam int WORD_W = 24;
    localparam int BIT_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        ST_ARM  = 2'd0,   // waiting for ready line to be high
        ST_IDLE = 2'd1,   // armed, waiting for ready line to fall
        ST_XFER = 2'd2    // serial burst in progress
    } cc_state_e;

    typedef struct packed {
        cc_state_e state;
        logic      cs_n;
        logic      err;
    } cc_ctrl_t;

endpackage

// File: rtl/cc_sclk_gen.sv
module cc_sclk_gen #(
    parameter int SCLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic sclk_o,
    output logic rise_o
);
    localparam int CNT_W = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SCLK_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sclk;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d = gen_q;
        if (!en_i) begin
            gen_d.cnt  = '0;
            gen_d.sclk = 1'b1;
        end else if (gen_q.cnt == CNT_LAST) begin
            gen_d.cnt  = '0;
            gen_d.sclk = ~gen_q.sclk;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q.cnt  <= '0;
            gen_q.sclk <= 1'b1;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign sclk_o = gen_q.sclk;
    assign rise_o = en_i && (gen_q.cnt == CNT_LAST) && !gen_q.sclk;

endmodule

// File: rtl/cc_deser.sv
module cc_deser
    import chain_collector_pkg::*;
#(
    parameter int NUM_DEV = 3,
    parameter int CHAN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic              last_o,
    output logic [WORD_W-1:0] word_o,
    output logic [CHAN_W-1:0] chan_o,
    output logic              valid_o
);
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(WORD_W - 1);
    localparam logic [CHAN_W-1:0] CHAN_LAST = CHAN_W'(NUM_DEV - 1);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [BIT_W-1:0]  bitc;
        logic [CHAN_W-1:0] chan;
        logic [WORD_W-1:0] word;
        logic [CHAN_W-1:0] wchan;
        logic              valid;
    } des_t;

    des_t des_d, des_q;
    logic [WORD_W-1:0] shifted;

    assign shifted = {des_q.sr[WORD_W-2:0], bit_i};

    always_comb begin
        des_d       = des_q;
        des_d.valid = 1'b0;
        if (clr_i) begin
            des_d.bitc = '0;
            des_d.chan = '0;
        end else if (shift_i) begin
            des_d.sr = shifted;
            if (des_q.bitc == BIT_LAST) begin
                des_d.bitc  = '0;
                des_d.word  = shifted;
                des_d.wchan = des_q.chan;
                des_d.valid = 1'b1;
                des_d.chan  = (des_q.chan == CHAN_LAST) ? '0 : des_q.chan + 1'b1;
            end else begin
                des_d.bitc = des_q.bitc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            des_q <= '0;
        end else begin
            des_q <= des_d;
        end
    end

    assign last_o  = shift_i && !clr_i && (des_q.bitc == BIT_LAST) && (des_q.chan == CHAN_LAST);
    assign word_o  = des_q.word;
    assign chan_o  = des_q.wchan;
    assign valid_o = des_q.valid;

endmodule

// File: rtl/chain_collector.sv
module chain_collector
    import chain_collector_pkg::*;
#(
    parameter int NUM_DEV  = 3,
    parameter int SCLK_DIV = 2,
    parameter int CHAN_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_en_i,
    input  logic              drdy_n_i,
    input  logic              sdo_i,
    output logic              sclk_o,
    output logic              cs_n_o,
    output logic [WORD_W-1:0] word_o,
    output logic [CHAN_W-1:0] chan_o,
    output logic              word_valid_o,
    output logic              err_o
);
    cc_ctrl_t ctl_d, ctl_q;
    logic     sclk_en;
    logic     rise;
    logic     last_bit;

    // Burst clock runs only in a transfer and stops at once when ready is withdrawn.
    assign sclk_en = (ctl_q.state == ST_XFER) && !drdy_n_i;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.err = 1'b0;
        unique case (ctl_q.state)
            ST_ARM:  if (drdy_n_i)  ctl_d.state = ST_IDLE;
            ST_IDLE: if (!drdy_n_i) ctl_d.state = ST_XFER;
            ST_XFER: begin
                if (last_bit) begin
                    ctl_d.state = ST_ARM;
                end else if (drdy_n_i) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.err   = 1'b1;
                end
            end
            default: ctl_d.state = ST_ARM;
        endcase
        ctl_d.cs_n = cs_en_i ? (ctl_d.state != ST_XFER) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_ARM;
            ctl_q.cs_n  <= 1'b1;
            ctl_q.err   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    cc_sclk_gen #(
        .SCLK_DIV (SCLK_DIV)
    ) u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (sclk_en),
        .sclk_o (sclk_o),
        .rise_o (rise)
    );

    cc_deser #(
        .NUM_DEV (NUM_DEV),
        .CHAN_W  (CHAN_W)
    ) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (ctl_q.state != ST_XFER),
        .shift_i (rise),
        .bit_i   (sdo_i),
        .last_o  (last_bit),
        .word_o  (word_o),
        .chan_o  (chan_o),
        .valid_o (word_valid_o)
    );

    assign cs_n_o = ctl_q.cs_n;
    assign err_o  = ctl_q.err;

endmodule

// File: rtl/chain_collector_chk.sv
module chain_collector_chk #(
    parameter int NUM_DEV = 3,
    parameter int CHAN_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_en_i,
    input logic              drdy_n_i,
    input logic              sclk_o,
    input logic              cs_n_o,
    input logic [CHAN_W-1:0] chan_o,
    input logic              word_valid_o,
    input logic              err_o
);
    // Select released implies the serial clock is parked high.
    p_sclk_parked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_en_i && cs_n_o) |-> sclk_o);

    p_chan_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> (int'(chan_o) < NUM_DEV));

    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o);

    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(drdy_n_i));

    p_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_o && word_valid_o));

    p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);
endmodule

bind chain_collector chain_collector_chk #(
    .NUM_DEV (NUM_DEV),
    .CHAN_W  (CHAN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_en_i      (cs_en_i),
    .drdy_n_i     (drdy_n_i),
    .sclk_o       (sclk_o),
    .cs_n_o       (cs_n_o),
    .chan_o       (chan_o),
    .word_valid_o (word_valid_o),
    .err_o        (err_o)
);

// File: tb/chain_collector_test.sv
module chain_collector_test;
    localparam int K      = 3;
    localparam int DIV    = 2;
    localparam int CW     = 2;
    localparam int NBITS  = 24 * K;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_en = 1'b1;
    logic drdy_n = 1'b0;
    logic sdo = 1'b0;
    logic sclk, cs_n, wvalid, err;
    logic [23:0] word;
    logic [CW-1:0] chan;

    int checks = 0;
    int errors = 0;
    int nfall = 0;
    int widx = 0;
    int errseen = 0;
    realtime t_first = 0.0;
    realtime t_last = 0.0;
    logic [NBITS-1:0] stream = '0;
    logic [23:0] dv [K];

    always #10 clk = ~clk;

    chain_collector #(.NUM_DEV(K), .SCLK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .cs_en_i(cs_en), .drdy_n_i(drdy_n),
        .sdo_i(sdo), .sclk_o(sclk), .cs_n_o(cs_n), .word_o(word),
        .chan_o(chan), .word_valid_o(wvalid), .err_o(err));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Chain model: a new bit appears after each falling edge; grounded far end.
    always @(negedge sclk) begin
        if (nfall == 0) t_first = $realtime;
        sdo = (nfall < NBITS) ? stream[NBITS-1-nfall] : 1'b0;
        nfall = nfall + 1;
    end
    always @(posedge sclk) t_last = $realtime;

    always @(negedge clk) begin
        if (err) errseen++;
        if (wvalid) begin
            if (widx < K) begin
                chk(int'(chan) == widx, "R5 chan order", chan, widx);
                chk(word == dv[widx], "R4 word value", word, dv[widx]);
            end else begin
                chk(1'b0, "R6 extra word", widx, K - 1);
            end
            widx++;
        end
    end

    function automatic logic [23:0] pat(input int f, input int d);
        case (f)
            0: pat = (d == 0) ? 24'h800000 : (d == 1) ? 24'h7FFFFF : 24'h000000;
            1: pat = 24'hFFFFFF;
            2: pat = 24'h000001 << (d * 11);
            3: pat = ~(24'h000001 << (d * 11));
            4: pat = 24'hA5A5A5 ^ 24'(d * 24'h0F0F0F);
            default: pat = 24'(f * 32'h2F1A3 + d * 32'h51B07 + 32'hC35);
        endcase
    endfunction

    task automatic load(input int f);
        for (int d = 0; d < K; d++) begin
            dv[d] = pat(f, d);
            stream[NBITS-1-24*d -: 24] = dv[d];
        end
        nfall = 0;
        widx = 0;
        errseen = 0;
    endtask

    task automatic frame(input int f, input bit csm, input int hold, input bit abort);
        load(f);
        cs_en = csm;
        @(negedge clk) drdy_n = 1'b0;
        repeat (20) @(negedge clk);
        chk(cs_n == 1'b0, "R7 select low in burst", cs_n, 0);
        repeat (hold - 20) @(negedge clk);
        drdy_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(sclk == 1'b1, "R8 sclk parked high", sclk, 1);
        chk(cs_n == csm, "R7 select level after burst", cs_n, csm);
        if (!abort) begin
            chk(nfall == NBITS, "R3 falling edge count", nfall, NBITS);
            chk(widx == K, "R6 word count", widx, K);
            chk(errseen == 0, "R8 no error on full frame", errseen, 0);
            chk(t_last - t_first == real'((2 * NBITS - 1) * DIV * 20),
                "R3 burst span ns", longint'(t_last - t_first), (2 * NBITS - 1) * DIV * 20);
        end else begin
            chk(errseen == 1, "R8 error pulse", errseen, 1);
            chk(widx < K, "R8 frame cut short", widx, K - 1);
            chk(nfall < NBITS, "R8 fewer edges", nfall, NBITS - 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        load(0);
        repeat (3) @(negedge clk);
        chk(sclk == 1'b1, "R1 reset sclk", sclk, 1);
        chk(cs_n == 1'b1, "R1 reset select", cs_n, 1);
        chk(wvalid == 1'b0, "R1 reset valid", wvalid, 0);
        chk(err == 1'b0, "R1 reset err", err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b1 && cs_n == 1'b1 && !wvalid && !err, "R1 after release", {sclk, cs_n, wvalid, err}, 4'b1100);
        // R2: ready low since reset must not start a burst
        repeat (100) @(negedge clk);
        chk(nfall == 0, "R2 no burst without arming", nfall, 0);
        chk(widx == 0, "R2 no words without arming", widx, 0);
        drdy_n = 1'b1;
        repeat (10) @(negedge clk);
        // R2: hold of 400 cycles outlasts the burst; edge count shows no retrigger
        for (int f = 0; f < 10; f++) frame(f, f[0] == 1'b0, 400, 1'b0);
        frame(5, 1'b1, 60, 1'b1);
        frame(6, 1'b1, 400, 1'b0);
        frame(7, 1'b1, 200, 1'b1);
        frame(1, 1'b0, 400, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule